// File: doc/BRIEF.md
# Voice Group Block-Chain Sequencer

The sequencer plays a voice group by stepping through a list of fixed-length sample blocks and handing one block index at a time to a block reader. A group table gives each group the index of its first entry in an entry table, plus four per-group option bits. Each entry names a block, says whether that block holds 4-bit ADPCM or 8-bit PCM data, whether busy is driven while it plays, and whether it closes the group. The same block may appear in many groups, so a group can be any concatenation of stored blocks, for example blocks 13 to 15 followed by blocks 0 to 12.

A playback starts on a rising trigger. The group's options then decide what happens. Edge or level selects whether releasing the trigger matters. Hold selects whether the group loops. Retrigger selects whether a new rising trigger during playback restarts the group. The stop-pulse option selects whether a one-cycle end strobe marks the return to idle. The block reader holds a block while `fetch_valid_o` is high and signals `blk_done_i` for one cycle when that block has been fully consumed. Both tables are register arrays written through dedicated write ports.

Top module: `voice_seq`

## Requirements
- R1: After reset, fetch_valid_o, busy_o and end_o are all low.
- R2: In idle, a 0-to-1 change of trig_i latches grp_i. In the next cycle fetch_valid_o is high and fetch_blk_o shows the block of that group's first entry. A trigger that stays high without a new rising change starts nothing. Group word: bits [3:0] are the options, bits [ENT_W+3:4] are the first entry index.
- R3: A blk_done_i pulse on an entry whose last flag is clear moves to the next entry index in the following cycle. Entry word: bits [BLK_W-1:0] block, bit BLK_W PCM flag (fetch_pcm_o), bit BLK_W+1 busy flag, bit BLK_W+2 last flag.
- R4: busy_o is high only while playing, and it equals the busy flag of the entry being played.
- R5: A group without the hold option (bit 1) that is edge triggered (bit 0 set) returns to idle in the cycle after blk_done_i on its last entry.
- R6: An edge-triggered group with the hold option loops from its last entry back to its first entry.
- R7: A level-triggered group (bit 0 clear) with hold loops while trig_i is high. If trig_i is low at a blk_done_i, playback ends after that block.
- R8: A level-triggered group without hold goes idle in the cycle after trig_i is seen low.
- R9: With the retrigger option (bit 2), a rising trig_i during playback restarts the group at its first entry in the next cycle.
- R10: Without the retrigger option, a rising trig_i during playback leaves the current block in place.
- R11: stop_i has top priority. In the next cycle fetch_valid_o and busy_o are low.
- R12: When playback returns to idle for any reason, end_o is high for exactly one cycle if and only if the stop-pulse option (bit 3) of the group is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| grp_we_i | input | 1 | Group table write enable |
| grp_waddr_i | input | GRP_W | Group table write index |
| grp_wdata_i | input | ENT_W+4 | Group word: first entry and options |
| ent_we_i | input | 1 | Entry table write enable |
| ent_waddr_i | input | ENT_W | Entry table write index |
| ent_wdata_i | input | BLK_W+3 | Entry word: last, busy, PCM, block |
| trig_i | input | 1 | Trigger level |
| grp_i | input | GRP_W | Group to start on a rising trigger |
| stop_i | input | 1 | Stop request |
| blk_done_i | input | 1 | Reader finished the current block |
| fetch_valid_o | output | 1 | A block is being requested |
| fetch_blk_o | output | BLK_W | Block index requested |
| fetch_pcm_o | output | 1 | 1 = 8-bit PCM, 0 = 4-bit ADPCM |
| busy_o | output | 1 | Busy flag of the current entry |
| end_o | output | 1 | One-cycle end-of-playback strobe |

## Verification
Directed sequences drive each of the option combinations: edge without hold, edge with hold, level with hold, level without hold, retriggerable and non-retriggerable. Each sequence is built so that the next block seen on the port differs between the correct branch and its neighbours: looping versus ending, advancing versus restarting, and staying versus dropping on release. Randomized entry tables then run edge groups with random starting entries, flags, chain lengths and reader delays. A bench function walks the chain to predict every block, PCM flag and busy value, and whether end_o pulses at the end.

// File: rtl/voice_seq_pkg.sv
package voice_seq_pkg;
  localparam int unsigned OPT_W = 4;

  // bit 0 edge_trig, bit 1 hold, bit 2 retrig, bit 3 stop_en
  typedef struct packed {
    logic stop_en;
    logic retrig;
    logic hold;
    logic edge_trig;
  } grp_opt_t;
endpackage

// File: rtl/voice_seq_regfile.sv
module voice_seq_regfile #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/voice_seq_ctrl.sv
module voice_seq_ctrl
  import voice_seq_pkg::*;
#(
  parameter int unsigned GRP_W = 3,
  parameter int unsigned ENT_W = 4,
  parameter int unsigned BLK_W = 6,
  localparam int unsigned GW   = ENT_W + OPT_W,
  localparam int unsigned EW   = BLK_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             stop_i,
  input  logic             blk_done_i,
  input  logic [GW-1:0]    grp_word_i,
  input  logic [EW-1:0]    ent_word_i,
  output logic [GRP_W-1:0] grp_raddr_o,
  output logic [ENT_W-1:0] ent_raddr_o,
  output logic             fetch_valid_o,
  output logic [BLK_W-1:0] fetch_blk_o,
  output logic             fetch_pcm_o,
  output logic             busy_o,
  output logic             end_o
);
  logic             play_q, play_d;
  logic             end_q, end_d;
  logic             trig_q;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [ENT_W-1:0] ptr_q, ptr_d;

  grp_opt_t         opt;
  logic [ENT_W-1:0] start_ptr;
  logic             trig_rise, ent_last;

  assign opt         = grp_opt_t'(grp_word_i[OPT_W-1:0]);
  assign start_ptr   = grp_word_i[GW-1:OPT_W];
  assign ent_last    = ent_word_i[BLK_W+2];
  assign trig_rise   = trig_i & ~trig_q;
  // idle: look up the requested group; playing: the latched one
  assign grp_raddr_o = play_q ? grp_q : grp_i;
  assign ent_raddr_o = ptr_q;

  always_comb begin
    play_d = play_q;
    grp_d  = grp_q;
    ptr_d  = ptr_q;
    end_d  = 1'b0;
    if (!play_q) begin
      if (trig_rise && !stop_i) begin
        play_d = 1'b1;
        grp_d  = grp_i;
        ptr_d  = start_ptr;
      end
    end else if (stop_i || (!opt.edge_trig && !opt.hold && !trig_i)) begin
      play_d = 1'b0;
      end_d  = opt.stop_en;
    end else if (trig_rise && opt.retrig) begin
      ptr_d = start_ptr;
    end else if (blk_done_i) begin
      if (!opt.edge_trig && opt.hold && !trig_i) begin
        play_d = 1'b0;
        end_d  = opt.stop_en;
      end else if (!ent_last) begin
        ptr_d = ptr_q + 1'b1;
      end else if (opt.hold) begin
        ptr_d = start_ptr;
      end else begin
        play_d = 1'b0;
        end_d  = opt.stop_en;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      play_q <= 1'b0;
      end_q  <= 1'b0;
      trig_q <= 1'b0;
      grp_q  <= '0;
      ptr_q  <= '0;
    end else begin
      play_q <= play_d;
      end_q  <= end_d;
      trig_q <= trig_i;
      grp_q  <= grp_d;
      ptr_q  <= ptr_d;
    end
  end

  assign fetch_valid_o = play_q;
  assign fetch_blk_o   = ent_word_i[BLK_W-1:0];
  assign fetch_pcm_o   = ent_word_i[BLK_W];
  assign busy_o        = play_q & ent_word_i[BLK_W+1];
  assign end_o         = end_q;

  p_stop_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !fetch_valid_o && !busy_o);

  p_end_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);

  p_end_when_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !fetch_valid_o);

  p_release_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_q && !opt.edge_trig && !opt.hold && !trig_i) |=> !play_q);

  p_retrig_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_q && trig_rise && opt.retrig && !stop_i && !(!opt.edge_trig && !opt.hold && !trig_i))
    |=> play_q && ptr_q == $past(start_ptr));

  p_no_retrig_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (play_q && trig_rise && !opt.retrig && !stop_i && !blk_done_i)
    |=> $stable(ptr_q) && play_q);

  p_busy_play_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> fetch_valid_o);
endmodule

// File: rtl/voice_seq.sv
module voice_seq
  import voice_seq_pkg::*;
#(
  parameter int unsigned GRP_W = 3,
  parameter int unsigned ENT_W = 4,
  parameter int unsigned BLK_W = 6,
  localparam int unsigned GW   = ENT_W + OPT_W,
  localparam int unsigned EW   = BLK_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_we_i,
  input  logic [GRP_W-1:0] grp_waddr_i,
  input  logic [GW-1:0]    grp_wdata_i,
  input  logic             ent_we_i,
  input  logic [ENT_W-1:0] ent_waddr_i,
  input  logic [EW-1:0]    ent_wdata_i,
  input  logic             trig_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic             stop_i,
  input  logic             blk_done_i,
  output logic             fetch_valid_o,
  output logic [BLK_W-1:0] fetch_blk_o,
  output logic             fetch_pcm_o,
  output logic             busy_o,
  output logic             end_o
);
  logic [GRP_W-1:0] grp_raddr;
  logic [ENT_W-1:0] ent_raddr;
  logic [GW-1:0]    grp_word;
  logic [EW-1:0]    ent_word;

  voice_seq_regfile #(.DEPTH(1 << GRP_W), .W(GW)) i_grp_tab (
    .clk_i, .rst_ni,
    .we_i(grp_we_i), .waddr_i(grp_waddr_i), .wdata_i(grp_wdata_i),
    .raddr_i(grp_raddr), .rdata_o(grp_word)
  );

  voice_seq_regfile #(.DEPTH(1 << ENT_W), .W(EW)) i_ent_tab (
    .clk_i, .rst_ni,
    .we_i(ent_we_i), .waddr_i(ent_waddr_i), .wdata_i(ent_wdata_i),
    .raddr_i(ent_raddr), .rdata_o(ent_word)
  );

  voice_seq_ctrl #(.GRP_W(GRP_W), .ENT_W(ENT_W), .BLK_W(BLK_W)) i_ctrl (
    .clk_i, .rst_ni, .trig_i, .grp_i, .stop_i, .blk_done_i,
    .grp_word_i(grp_word), .ent_word_i(ent_word),
    .grp_raddr_o(grp_raddr), .ent_raddr_o(ent_raddr),
    .fetch_valid_o, .fetch_blk_o, .fetch_pcm_o, .busy_o, .end_o
  );
endmodule

// File: tb/test_voice_seq.sv
module test_voice_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       grp_we = 1'b0, ent_we = 1'b0;
  logic [2:0] grp_waddr = '0;
  logic [7:0] grp_wdata = '0;
  logic [3:0] ent_waddr = '0;
  logic [8:0] ent_wdata = '0;
  logic       trig = 1'b0, stop = 1'b0, done = 1'b0;
  logic [2:0] grp = '0;
  logic       valid, pcm, busy, endp;
  logic [5:0] blk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit fin = 1'b0;

  int m_blk [16];
  bit m_pcm [16], m_busy [16], m_last [16];

  always #10 clk = ~clk;

  voice_seq i_voice_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .grp_we_i(grp_we), .grp_waddr_i(grp_waddr), .grp_wdata_i(grp_wdata),
    .ent_we_i(ent_we), .ent_waddr_i(ent_waddr), .ent_wdata_i(ent_wdata),
    .trig_i(trig), .grp_i(grp), .stop_i(stop), .blk_done_i(done),
    .fetch_valid_o(valid), .fetch_blk_o(blk), .fetch_pcm_o(pcm),
    .busy_o(busy), .end_o(endp)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ent(int e, int b, bit p, bit bz, bit l);
    m_blk[e] = b; m_pcm[e] = p; m_busy[e] = bz; m_last[e] = l;
    ent_we = 1'b1; ent_waddr = 4'(e); ent_wdata = {l, bz, p, 6'(b)};
    tick(); ent_we = 1'b0;
  endtask

  task automatic wr_grp(int g, int start, int opt);
    grp_we = 1'b1; grp_waddr = 3'(g); grp_wdata = {4'(start), 4'(opt)};
    tick(); grp_we = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; tick(); done = 1'b0;
  endtask

  task automatic start_grp(int g);
    grp = 3'(g); trig = 1'b1; tick(); trig = 1'b0;
  endtask

  // expected entry following e in a chain (bench model of R3)
  function automatic int next_ent(int e);
    return e + 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R1 valid", valid, 0); chk("R1 busy", busy, 0); chk("R1 end", endp, 0);
    rst_ni = 1'b1;
    tick();
    chk("R1 valid after release", valid, 0);

    wr_ent(0, 13, 0, 1, 0); wr_ent(1, 14, 1, 0, 0); wr_ent(2, 15, 0, 1, 1);
    wr_ent(3, 5, 0, 1, 0);  wr_ent(4, 6, 1, 0, 1);
    wr_grp(1, 0, 4'b1001);  // edge, stop pulse
    wr_grp(3, 3, 4'b0011);  // edge, hold
    wr_grp(4, 3, 4'b1010);  // level, hold, stop pulse
    wr_grp(5, 0, 4'b0000);  // level, no hold
    wr_grp(6, 0, 4'b0101);  // edge, retrigger

    // R2/R3/R4/R5/R12: edge without hold, trigger kept high throughout
    grp = 3'd1; trig = 1'b1; tick();
    chk("R2 valid", valid, 1); chk("R2 blk", blk, 13);
    chk("R2 pcm", pcm, 0); chk("R4 busy set", busy, 1);
    pulse_done();
    chk("R3 blk", blk, 14); chk("R3 pcm", pcm, 1); chk("R4 busy clear", busy, 0);
    pulse_done();
    chk("R3 blk last", blk, 15);
    pulse_done();
    chk("R5 idle", valid, 0); chk("R12 end", endp, 1); chk("R4 busy idle", busy, 0);
    tick();
    chk("R12 end one cycle", endp, 0); chk("R2 held trigger no start", valid, 0);
    trig = 1'b0; tick();

    // R6/R11/R12: edge with hold loops, stop ends, no end pulse
    start_grp(3);
    chk("R6 first", blk, 5);
    pulse_done(); chk("R6 second", blk, 6);
    pulse_done(); chk("R6 loop", blk, 5); chk("R6 valid", valid, 1);
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R11 valid", valid, 0); chk("R11 busy", busy, 0); chk("R12 no end", endp, 0);
    tick();

    // R7: level with hold
    grp = 3'd4; trig = 1'b1; tick();
    chk("R7 first", blk, 5);
    pulse_done(); chk("R7 second", blk, 6);
    pulse_done(); chk("R7 loop while high", blk, 5);
    trig = 1'b0; tick();
    chk("R7 release keeps block", valid, 1); chk("R7 release blk", blk, 5);
    pulse_done();
    chk("R7 ends after block", valid, 0); chk("R12 end level", endp, 1);
    tick();

    // R8: level without hold
    grp = 3'd5; trig = 1'b1; tick();
    chk("R8 playing", blk, 13);
    trig = 1'b0; tick();
    chk("R8 drop", valid, 0); chk("R12 no end R8", endp, 0);
    tick();

    // R9: retrigger
    start_grp(6);
    pulse_done(); chk("R9 advanced", blk, 14);
    trig = 1'b1; tick(); trig = 1'b0;
    chk("R9 restart", blk, 13); chk("R9 valid", valid, 1);
    stop = 1'b1; tick(); stop = 1'b0; tick();

    // R10: no retrigger, new group number also ignored
    start_grp(1);
    pulse_done(); chk("R10 advanced", blk, 14);
    grp = 3'd3; trig = 1'b1; tick(); trig = 1'b0;
    chk("R10 ignored", blk, 14); chk("R10 valid", valid, 1);
    tick(); chk("R10 still", blk, 14);
    stop = 1'b1; tick(); stop = 1'b0;
    chk("R11 stop idle", valid, 0); chk("R12 end on stop", endp, 1);
    tick();

    // randomized edge chains on entries 8..15
    begin
      int unsigned seed = $urandom(32'd4711);
      for (int it = 0; it < 16; it++) begin
        int st, e, se;
        for (int k = 8; k < 16; k++)
          wr_ent(k, int'($urandom_range(63)), 1'($urandom_range(1)),
                 1'($urandom_range(1)), (k == 15) ? 1'b1 : ($urandom_range(3) == 0));
        st = 8 + int'($urandom_range(7));
        se = int'($urandom_range(1));
        wr_grp(7, st, (se << 3) | 1);
        start_grp(7);
        e = st;
        while (1) begin
          chk("R3 rand valid", valid, 1);
          chk("R3 rand blk", blk, m_blk[e]);
          chk("R2 rand pcm", pcm, m_pcm[e]);
          chk("R4 rand busy", busy, m_busy[e]);
          for (int w = int'($urandom_range(2)); w > 0; w--) tick();
          chk("R3 rand hold blk", blk, m_blk[e]);
          pulse_done();
          if (m_last[e]) break;
          e = next_ent(e);
        end
        chk("R5 rand idle", valid, 0);
        chk("R12 rand end", endp, se);
        tick();
        if (seed == 0) tick();
      end
    end

    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule